// File: doc/BRIEF.md
# Double-Buffered Synchronous Serial Receiver

This block takes a serial bit stream from an external sender and turns it into parallel words for a host. The sender supplies three signals: a serial clock, a frame-sync, and a data line. All three are brought into the system clock domain through a two-flop synchronizer. A data bit is taken on every falling edge of the synchronized serial clock. Bits collect MSB first in a shift register. When the shift register holds a complete word, it is copied into a holding register. The copy raises a ready flag and a one-cycle interrupt pulse. The host then reads the word with a single-cycle read strobe.

Words are 16 bits or 8 bits long. Framing has two modes. In burst framing, every word starts with its own frame-sync. In continuous framing, one frame-sync starts the stream and later words follow back to back.

Overrun occurs when a new word completes while the previous one is still unread. On overrun, the receiver stops shifting and throws away incoming bits, but keeps the completed word. It delivers that word as soon as the host has read the older one. The overrun flag rises at once in continuous framing. In burst framing it rises only when a further frame-sync arrives.

Top module: `ser_rx_dbuf`

## Requirements
- R1: Bits are assembled MSB first. With `cfg_byte`=0 a word is 16 bits, and the first bit received appears at bit 15 of `rd_data`.
- R2: With `cfg_byte`=1 a word is 8 bits. It appears in `rd_data[7:0]`, and `rd_data[15:8]` reads 0.
- R3: With `cfg_burst`=1, a word begins only on a bit taken while `rx_fs` is high. Bits taken with no frame-sync since the last completed word are discarded, and neither `rd_data` nor `rx_ready` changes.
- R4: With `cfg_burst`=0, one frame-sync starts reception and later words follow with no frame-sync. A frame-sync seen mid-word restarts alignment, and that bit becomes the MSB of a new word.
- R5: Each transfer into the holding register sets `rx_ready` and gives exactly one `rx_irq` pulse of one cycle. `rd_data` changes only on such a transfer or on device reset.
- R6: A host read (`rd_en` high for one cycle) clears `rx_ready` in the next cycle.
- R7: If a word completes while `rx_ready` is still 1, the word stays in the shift register and further bits are discarded. After the host read, that preserved word is transferred with a new `rx_ready`/`rx_irq`. `rx_ovr` is only ever high while `rx_ready` is high. In continuous framing `rx_ovr` rises in the cycle after the word completes.
- R8: In burst framing, a pending overrun leaves `rx_ovr` low until a bit is taken while `rx_fs` is high. `rx_ovr` then rises.
- R9: `rx_ovr` is cleared by a host read, and a read in the same cycle wins over a new overrun.
- R10: Device reset clears `rd_data`, `rx_ready`, `rx_irq` and `rx_ovr`. Taking `cfg_rx_en` low clears `rx_ready` and `rx_ovr` and abandons any partial word, but leaves `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low device reset |
| cfg_rx_en | input | 1 | Receiver enable; 0 holds the receiver in reset |
| cfg_byte | input | 1 | Word length select: 0 = 16 bits, 1 = 8 bits |
| cfg_burst | input | 1 | Framing select: 1 = burst, 0 = continuous |
| rx_clk | input | 1 | Serial bit clock, asynchronous |
| rx_fs | input | 1 | Receive frame-sync, asynchronous |
| rx_dat | input | 1 | Serial data, asynchronous |
| rd_en | input | 1 | Host read strobe for the holding register |
| rd_data | output | 16 | Holding register contents |
| rx_ready | output | 1 | A received word is waiting to be read |
| rx_irq | output | 1 | One-cycle pulse on every transfer into the holding register |
| rx_ovr | output | 1 | Overrun flag |

## Verification
The bench builds the block with its default parameters: a 16-bit word, an 8-bit short word and two synchronizer stages. This makes both word lengths reachable within a few hundred serial bits. The serial clock runs at one eighth of the system clock, so every bit crosses the synchronizer and the edge detector with room to spare. A cycle-level model in the bench tracks the synchronizer delay, so each transfer and each overrun is checked in the exact system cycle where it appears. The two framing modes, a mid-stream frame-sync, and overruns in both framings are all exercised on these defaults.

// File: rtl/rxs_pkg.sv
// Package rxs_pkg
// Shared widths and the framing-mode type for the serial receiver.
// Assumes a word of at most 16 bits on the host side.
package rxs_pkg;
    localparam int unsigned WORD_W = 16;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic {
        FRM_CONT  = 1'b0,
        FRM_BURST = 1'b1
    } frame_mode_e;
endpackage

// File: rtl/rxs_sync.sv
// Module rxs_sync
// Brings a vector of asynchronous single-bit signals into the clk domain
// through a chain of flops. Each bit is synchronized on its own; the
// signals are assumed to change slowly relative to clk.
module rxs_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        // one flop stage of the chain
        always_ff @(posedge clk) begin
            if (!rst_n)
                stg[i] <= '0;
            else if (i == 0)
                stg[i] <= d_in;
            else
                stg[i] <= stg[(i == 0) ? 0 : i-1];
        end
    end

    assign d_out = stg[STAGES-1];
endmodule

// File: rtl/rxs_shift.sv
// Module rxs_shift
// Detects falling edges of the synchronized serial clock, handles frame
// alignment and assembles MSB-first words. When a word is complete it
// holds it (full) until the holding side takes it; bits seen while full
// are dropped. Assumes synchronized inputs.
module rxs_shift
    import rxs_pkg::*;
#(
    parameter int unsigned W  = WORD_W,
    parameter int unsigned BW = BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         byte_mode,
    input  frame_mode_e  mode,
    input  logic         sclk_s,
    input  logic         fs_s,
    input  logic         dat_s,
    input  logic         take,
    output logic         full,
    output logic [W-1:0] word,
    output logic         fs_evt
);
    localparam int unsigned CW = $clog2(W + 1);

    logic          sclk_q;
    logic          fall;
    logic          active;
    logic [CW-1:0] cnt;
    logic [CW-1:0] wlen;
    logic [CW-1:0] cnt_nx;
    logic [W-1:0]  sh_nx;

    // bit strobe and frame-sync strobe from the synchronized clock
    always_comb begin
        fall   = sclk_q & ~sclk_s;
        fs_evt = fall & fs_s;
        wlen   = byte_mode ? CW'(BW) : CW'(W);
        cnt_nx = fs_s ? CW'(1) : cnt + 1'b1;
        sh_nx  = (fs_s || cnt == '0) ? {{(W-1){1'b0}}, dat_s}
                                     : {word[W-2:0], dat_s};
    end

    // edge history, alignment counter and shift register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            active <= 1'b0;
            full   <= 1'b0;
            cnt    <= '0;
            word   <= '0;
        end else begin
            sclk_q <= sclk_s;
            if (!en) begin
                active <= 1'b0;
                full   <= 1'b0;
                cnt    <= '0;
            end else begin
                if (take)
                    full <= 1'b0;
                if (fall && !full && (fs_s || active)) begin
                    word <= sh_nx;
                    if (cnt_nx == wlen) begin
                        full   <= 1'b1;
                        cnt    <= '0;
                        active <= (mode == FRM_CONT);
                    end else begin
                        cnt    <= cnt_nx;
                        active <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/rxs_hold.sv
// Module rxs_hold
// Holding register with ready, interrupt and overrun flags. Takes the
// completed word from the shifter whenever the previous one has been
// read. Assumes rd_en is a one-cycle strobe from the host.
module rxs_hold
    import rxs_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  frame_mode_e  mode,
    input  logic         full,
    input  logic         fs_evt,
    input  logic [W-1:0] word,
    input  logic         rd_en,
    output logic         take,
    output logic [W-1:0] hold,
    output logic         ready,
    output logic         irq,
    output logic         ovr
);
    // transfer whenever a word waits and the holding register is free
    assign take = full & ~ready & en;

    // holding register and status flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold  <= '0;
            ready <= 1'b0;
            irq   <= 1'b0;
            ovr   <= 1'b0;
        end else begin
            irq <= take;
            if (!en) begin
                ready <= 1'b0;
                ovr   <= 1'b0;
            end else begin
                if (take) begin
                    hold  <= word;
                    ready <= 1'b1;
                end else if (rd_en) begin
                    ready <= 1'b0;
                end
                if (rd_en)
                    ovr <= 1'b0;
                else if (full && ready && (mode == FRM_CONT || fs_evt))
                    ovr <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ser_rx_dbuf.sv
// Module ser_rx_dbuf (top)
// Double-buffered synchronous serial receiver: synchronizer, word
// assembler and holding register. Configuration inputs are assumed
// static while a word is in flight.
module ser_rx_dbuf
    import rxs_pkg::*;
#(
    parameter int unsigned W      = WORD_W,
    parameter int unsigned BW     = BYTE_W,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_rx_en,
    input  logic         cfg_byte,
    input  logic         cfg_burst,
    input  logic         rx_clk,
    input  logic         rx_fs,
    input  logic         rx_dat,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         rx_ready,
    output logic         rx_irq,
    output logic         rx_ovr
);
    logic [2:0]   sync_o;
    logic         full;
    logic         take;
    logic         fs_evt;
    logic [W-1:0] word;
    frame_mode_e  mode;

    assign mode = cfg_burst ? FRM_BURST : FRM_CONT;

    rxs_sync #(.W(3), .STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({rx_clk, rx_fs, rx_dat}),
        .d_out (sync_o)
    );

    rxs_shift #(.W(W), .BW(BW)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg_rx_en),
        .byte_mode (cfg_byte),
        .mode      (mode),
        .sclk_s    (sync_o[2]),
        .fs_s      (sync_o[1]),
        .dat_s     (sync_o[0]),
        .take      (take),
        .full      (full),
        .word      (word),
        .fs_evt    (fs_evt)
    );

    rxs_hold #(.W(W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (cfg_rx_en),
        .mode   (mode),
        .full   (full),
        .fs_evt (fs_evt),
        .word   (word),
        .rd_en  (rd_en),
        .take   (take),
        .hold   (rd_data),
        .ready  (rx_ready),
        .irq    (rx_irq),
        .ovr    (rx_ovr)
    );
endmodule

// File: rtl/rxs_checker.sv
// Module rxs_checker
// Temporal properties on the receiver's ports, attached by bind.
module rxs_checker #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cfg_rx_en,
    input logic         rd_en,
    input logic [W-1:0] rd_data,
    input logic         rx_ready,
    input logic         rx_irq,
    input logic         rx_ovr
);
    // interrupt is a single-cycle pulse
    assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);

    // interrupt accompanies a 0-to-1 step of the ready flag
    assert_irq_with_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> (rx_ready && !$past(rx_ready)));

    // holding register moves only together with an interrupt
    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_irq |-> $stable(rd_data));

    // a read of a ready word clears ready next cycle
    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rx_ready) |=> !rx_ready);

    // overrun never stands without a waiting word
    assert_ovr_needs_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovr |-> rx_ready);

    // read clears overrun
    assert_read_clears_ovr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rx_ovr);

    // receiver disable clears both flags
    assert_disable_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rx_en |=> (!rx_ready && !rx_ovr));
endmodule

bind ser_rx_dbuf rxs_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_rx_en (cfg_rx_en),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .rx_ready  (rx_ready),
    .rx_irq    (rx_irq),
    .rx_ovr    (rx_ovr)
);

// File: tb/sim_ser_rx_dbuf.sv
`timescale 1ns/1ps
module sim_ser_rx_dbuf;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_rx_en = 1'b0, cfg_byte = 1'b0, cfg_burst = 1'b1;
    logic        rx_clk = 1'b0, rx_fs = 1'b0, rx_dat = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        rx_ready, rx_irq, rx_ovr;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ser_rx_dbuf u0 (
        .clk(clk), .rst_n(rst_n), .cfg_rx_en(cfg_rx_en), .cfg_byte(cfg_byte),
        .cfg_burst(cfg_burst), .rx_clk(rx_clk), .rx_fs(rx_fs), .rx_dat(rx_dat),
        .rd_en(rd_en), .rd_data(rd_data), .rx_ready(rx_ready),
        .rx_irq(rx_irq), .rx_ovr(rx_ovr)
    );

    // behavioural reference: input history queues plus word-level state
    bit q_clk[$], q_fs[$], q_dat[$];
    int m_cnt, m_sh, m_hold;
    bit m_active, m_full, m_ready, m_irq, m_ovr;

    initial begin
        q_clk = '{0, 0, 0};
        q_fs  = '{0, 0};
        q_dat = '{0, 0};
    end

    always @(posedge clk) begin
        bit fall, fse, tk, fs_b, d_b, n_full;
        int wl, ncnt, nsh;
        if (!rst_n) begin
            q_clk = '{0, 0, 0}; q_fs = '{0, 0}; q_dat = '{0, 0};
            m_cnt = 0; m_sh = 0; m_hold = 0;
            m_active = 0; m_full = 0; m_ready = 0; m_irq = 0; m_ovr = 0;
        end else begin
            // q_clk[2] is the oldest synchronized sample, q_*[1] the current one
            fall = q_clk[2] && !q_clk[1];
            fs_b = q_fs[1];
            d_b  = q_dat[1];
            fse  = fall && fs_b;
            wl   = cfg_byte ? 8 : 16;
            tk   = m_full && !m_ready && cfg_rx_en;
            n_full = m_full;
            m_irq = tk;
            if (!cfg_rx_en) begin
                m_ovr = 0;
                if (!tk) m_ready = 0;
                m_ready = 0;
                m_active = 0; m_cnt = 0; n_full = 0;
            end else begin
                if (rd_en) m_ovr = 0;
                else if (m_full && m_ready && (!cfg_burst || fse)) m_ovr = 1;
                if (tk) begin m_hold = m_sh; m_ready = 1; n_full = 0; end
                else if (rd_en) m_ready = 0;
                if (fall && !m_full && (fs_b || m_active)) begin
                    ncnt = fs_b ? 1 : m_cnt + 1;
                    nsh  = (fs_b || m_cnt == 0) ? int'(d_b) : (((m_sh << 1) | int'(d_b)) & 16'hFFFF);
                    m_sh = nsh;
                    if (ncnt == wl) begin
                        n_full = 1; m_cnt = 0; m_active = !cfg_burst;
                    end else begin
                        m_cnt = ncnt; m_active = 1;
                    end
                end
            end
            m_full = n_full;
        end
        void'(q_clk.pop_back()); q_clk.push_front(rx_clk);
        void'(q_fs.pop_back());  q_fs.push_front(rx_fs);
        void'(q_dat.pop_back()); q_dat.push_front(rx_dat);
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (rd_data !== m_hold[15:0]) begin
                errors++;
                $display("FAIL R1 model rd_data actual=%h expected=%h", rd_data, m_hold[15:0]);
            end
            checks++;
            if (rx_ready !== m_ready || rx_irq !== m_irq) begin
                errors++;
                $display("FAIL R5 model ready/irq actual=%b%b expected=%b%b",
                         rx_ready, rx_irq, m_ready, m_irq);
            end
            checks++;
            if (rx_ovr !== m_ovr) begin
                errors++;
                $display("FAIL R7 model ovr actual=%b expected=%b", rx_ovr, m_ovr);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bit(input bit fs, input bit d);
        @(negedge clk);
        rx_clk = 1'b1; rx_fs = fs; rx_dat = d;
        repeat (4) @(negedge clk);
        rx_clk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_word(input int val, input int nb, input bit fs);
        for (int i = nb - 1; i >= 0; i--)
            send_bit(fs && (i == nb - 1), val[i]);
        rx_fs = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic host_read();
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset rd_data", rd_data, 0);
        chk("R10 reset flags", {rx_ready, rx_irq, rx_ovr}, 0);
        rst_n = 1'b1; cfg_rx_en = 1'b1;
        repeat (3) @(negedge clk);

        // burst, 16-bit
        send_word(16'hB3C6, 16, 1);
        chk("R1 burst word", rd_data, 16'hB3C6);
        chk("R5 ready set", rx_ready, 1);
        host_read();
        chk("R6 ready cleared by read", rx_ready, 0);

        // burst: bits without frame-sync are dropped
        send_word(16'h1111, 16, 0);
        chk("R3 unframed data ignored", rd_data, 16'hB3C6);
        chk("R3 unframed no ready", rx_ready, 0);

        // 8-bit mode
        cfg_byte = 1'b1;
        send_word(8'hA5, 8, 1);
        chk("R2 byte right-justified", rd_data, 16'h00A5);
        host_read();

        // continuous, 16-bit
        cfg_byte = 1'b0; cfg_burst = 1'b0;
        send_word(16'h8001, 16, 1);
        chk("R4 first framed word", rd_data, 16'h8001);
        host_read();
        send_word(16'h7E5A, 16, 0);
        chk("R4 back-to-back word", rd_data, 16'h7E5A);
        chk("R4 back-to-back ready", rx_ready, 1);
        host_read();
        for (int i = 0; i < 5; i++) send_bit(0, 1);
        send_word(16'h1234, 16, 1);
        chk("R4 realign on frame-sync", rd_data, 16'h1234);
        host_read();

        // continuous overrun
        send_word(16'hAAAA, 16, 0);
        send_word(16'h5555, 16, 0);
        chk("R7 continuous overrun flag", rx_ovr, 1);
        chk("R7 older word kept", rd_data, 16'hAAAA);
        for (int i = 0; i < 4; i++) send_bit(0, 1);
        host_read();
        chk("R9 read clears overrun", rx_ovr, 0);
        chk("R7 preserved word delivered", rd_data, 16'h5555);
        chk("R7 preserved word ready", rx_ready, 1);
        host_read();

        // receiver disable
        send_word(16'h0F0F, 16, 0);
        chk("R10 word before disable", rx_ready, 1);
        @(negedge clk); cfg_rx_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 disable clears ready", rx_ready, 0);
        chk("R10 disable keeps data", rd_data, 16'h0F0F);
        cfg_rx_en = 1'b1;

        // burst overrun, 8-bit
        cfg_burst = 1'b1; cfg_byte = 1'b1;
        send_word(8'h3C, 8, 1);
        send_word(8'hC3, 8, 1);
        chk("R8 no flag before frame-sync", rx_ovr, 0);
        send_bit(1, 0);
        rx_fs = 1'b0;
        repeat (4) @(negedge clk);
        chk("R8 flag on frame-sync", rx_ovr, 1);
        host_read();
        chk("R7 burst preserved byte", rd_data, 16'h00C3);
        chk("R9 overrun cleared", rx_ovr, 0);

        // device reset
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 reset clears data", rd_data, 0);
        chk("R10 reset clears flags", {rx_ready, rx_ovr}, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule